// File: doc/BRIEF.md
# Cascaded Timer with Coherent Capture

This block is a wide free-running time base made from two equal counter halves. The low half counts on every enabled cycle. When it wraps, it sends a carry to the high half through a pipeline of `CARRY_DLY` registers, so the high half steps up a few cycles after the wrap. The live count output hides this lag. It adds any carry still in the pipeline to the high half, so the full-width count always reads as one consistent number.

A capture strobe latches both raw halves in the same cycle. The strobe can land after a low wrap but before the delayed carry reaches the high half. In that case the raw pair is a wrapped low half next to a stale high half.

A correction stage waits `CARRY_DLY` cycles after the strobe, which is long enough for any carry already in flight to settle. It then chooses the high half:

- If the captured low half is below `THRESH`, it uses the live high register.
- Otherwise it uses the latched high half.

The result is the chosen high half joined to the captured low half. It leaves the block on a valid/ready output. `cap_valid` stays high with `cap_data` held steady until `cap_ready` is sampled high. A transfer completes on any clock edge where both are high. Back-pressure never stalls the counters.

A new strobe may arrive while an earlier result is still being corrected or is waiting for `cap_ready`. The new strobe then replaces the older result and sets a sticky overrun flag.

Top module: `cascade_timer_capture`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `count` = 0, `cap_valid` = 0 and `cap_overrun` = 0.
- R2: `count` rises by exactly one after each edge with `cnt_en` high, and holds after each edge with `cnt_en` low. This includes the edges around a low-half wrap from all-ones to zero, so `count` never shows a stale high half.
- R3: When `cap_in` is sampled high at edge E and no later strobe replaces it, `cap_valid` first rises after edge E + `CARRY_DLY`.
- R4: `cap_data` equals the `count` value present just before the edge that sampled `cap_in`. This holds for strobes that land within `CARRY_DLY` cycles after a low wrap (low half below `THRESH`, settled live high half used).
- R5: A strobe taken while the low half is at or above `THRESH`, including the all-ones value just before a wrap, delivers the latched high half unchanged.
- R6: While `cap_valid` is high and `cap_ready` is low, and no new strobe arrives, `cap_valid` stays high and `cap_data` stays unchanged.
- R7: A strobe sampled while a result is pending or is held unaccepted sets `cap_overrun`. The older result is discarded and is never delivered, and only the newer one appears.
- R8: A strobe sampled on the same edge where a held result is accepted (`cap_valid` and `cap_ready` both high) does not set `cap_overrun`, and both results are delivered in order.
- R9: Once set, `cap_overrun` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable for the low half |
| cap_in | input | 1 | Capture strobe, sampled each edge |
| cap_ready | input | 1 | Consumer ready for the corrected capture |
| cap_valid | output | 1 | Corrected capture available |
| cap_data | output | 2*CNT_W | Corrected capture value |
| cap_overrun | output | 1 | Sticky: a pending or held capture was replaced |
| count | output | 2*CNT_W | Coherent live count |

## Verification
Two pairs of events can share a cycle.

The first pair is a strobe and the delayed carry still crossing into the high half. The bench shrinks the halves to 8 bits and strobes at several fixed spacings with a pseudo-random count enable, so strobes fall at every phase around many wraps. Each delivered value is compared with a reference count kept in the bench.

The second pair is a strobe and the output handshake, or a strobe and the end of a pending correction. Strobes spaced exactly `CARRY_DLY`+1 cycles apart must never set the overrun flag. Strobes spaced one cycle apart, or strobes that arrive while a result is held back, must set it and must deliver only the newer value.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  // Raw pair latched by the capture strobe.
  typedef struct packed {
    logic [15:0] lo;
    logic [15:0] hi;
  } ctc_raw16_t;

  // Width of a down-counter that must hold the value n.
  function automatic int ctc_cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/ctc_low_cnt.sv
module ctc_low_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] lo,
  output logic         wrap
);
  localparam logic [W-1:0] LO_MAX = {W{1'b1}};

  // Combinational: this enabled edge takes the low half from all-ones to zero.
  assign wrap = en && (lo == LO_MAX);

  always_ff @(posedge clk) begin
    if (rst)     lo <= '0;
    else if (en) lo <= lo + 1'b1;
  end
endmodule

// File: rtl/ctc_carry_pipe.sv
module ctc_carry_pipe #(
  parameter int DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic carry_in,
  output logic carry_out,
  output logic in_flight
);
  logic [DLY-1:0] stage;

  generate
    if (DLY == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) stage <= '0;
        else     stage[0] <= carry_in;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) stage <= '0;
        else     stage <= {stage[DLY-2:0], carry_in};
      end
    end
  endgenerate

  assign carry_out = stage[DLY-1];
  assign in_flight = |stage;
endmodule

// File: rtl/ctc_high_cnt.sv
module ctc_high_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] hi
);
  always_ff @(posedge clk) begin
    if (rst)       hi <= '0;
    else if (step) hi <= hi + 1'b1;
  end
endmodule

// File: rtl/ctc_capture_fix.sv
module ctc_capture_fix #(
  parameter int W      = 16,
  parameter int DLY    = 2,
  parameter int THRESH = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           strobe,
  input  logic [W-1:0]   lo_now,
  input  logic [W-1:0]   hi_now,
  input  logic           out_ready,
  output logic           out_valid,
  output logic [2*W-1:0] out_data,
  output logic           overrun
);
  localparam int CW = ctc_pkg::ctc_cnt_w(DLY);
  localparam logic [CW-1:0] WAIT_INIT = CW'(DLY);
  localparam logic [W-1:0]  THR_V     = W'(THRESH);

  logic [W-1:0]  raw_lo, raw_hi;
  logic          pend;
  logic [CW-1:0] wait_cnt;
  logic          settle_now;
  logic [W-1:0]  pick_hi;
  logic          busy;

  assign settle_now = pend && (wait_cnt == CW'(1));
  assign pick_hi    = (raw_lo < THR_V) ? hi_now : raw_hi;
  assign busy       = pend || (out_valid && !out_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_lo    <= '0;
      raw_hi    <= '0;
      pend      <= 1'b0;
      wait_cnt  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      overrun   <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (settle_now) begin
        out_valid <= 1'b1;
        out_data  <= {pick_hi, raw_lo};
        pend      <= 1'b0;
      end else if (pend) begin
        wait_cnt <= wait_cnt - 1'b1;
      end
      if (strobe) begin
        if (busy) overrun <= 1'b1;
        raw_lo    <= lo_now;
        raw_hi    <= hi_now;
        pend      <= 1'b1;
        wait_cnt  <= WAIT_INIT;
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cascade_timer_capture.sv
module cascade_timer_capture #(
  parameter int CNT_W     = 16,
  parameter int CARRY_DLY = 2,
  parameter int THRESH    = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cnt_en,
  input  logic               cap_in,
  input  logic               cap_ready,
  output logic               cap_valid,
  output logic [2*CNT_W-1:0] cap_data,
  output logic               cap_overrun,
  output logic [2*CNT_W-1:0] count
);
  localparam int TOT_W = 2 * CNT_W;

  logic [CNT_W-1:0] lo, hi;
  logic             wrap, carry, in_flight;

  ctc_low_cnt #(.W(CNT_W)) u_lo (
    .clk(clk), .rst(rst), .en(cnt_en), .lo(lo), .wrap(wrap)
  );

  ctc_carry_pipe #(.DLY(CARRY_DLY)) u_pipe (
    .clk(clk), .rst(rst), .carry_in(wrap),
    .carry_out(carry), .in_flight(in_flight)
  );

  ctc_high_cnt #(.W(CNT_W)) u_hi (
    .clk(clk), .rst(rst), .step(carry), .hi(hi)
  );

  ctc_capture_fix #(.W(CNT_W), .DLY(CARRY_DLY), .THRESH(THRESH)) u_fix (
    .clk(clk), .rst(rst), .strobe(cap_in), .lo_now(lo), .hi_now(hi),
    .out_ready(cap_ready), .out_valid(cap_valid), .out_data(cap_data),
    .overrun(cap_overrun)
  );

  // At most one carry is ever in flight, because CARRY_DLY is much shorter than a low period.
  assign count = TOT_W'({hi + CNT_W'(in_flight), lo});
endmodule

// File: rtl/ctc_checker.sv
module ctc_checker #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               cnt_en,
  input logic               cap_in,
  input logic               cap_ready,
  input logic               cap_valid,
  input logic [2*CNT_W-1:0] cap_data,
  input logic               cap_overrun,
  input logic [2*CNT_W-1:0] count
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (count == '0) && !cap_valid && !cap_overrun);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> count == $past(count) + 1'b1);

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(count));

  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && !cap_ready && !cap_in) |=> cap_valid && $stable(cap_data));

  // R7
  replace_held_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_in && cap_valid && !cap_ready) |=> cap_overrun && !cap_valid);

  // R9
  sticky_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    cap_overrun |=> cap_overrun);
endmodule

bind cascade_timer_capture ctc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .cap_in(cap_in),
  .cap_ready(cap_ready), .cap_valid(cap_valid), .cap_data(cap_data),
  .cap_overrun(cap_overrun), .count(count)
);

// File: tb/sim_cascade_timer_capture.sv
module sim_cascade_timer_capture;
  localparam int W   = 8;
  localparam int D   = 3;
  localparam int THR = 16;
  localparam int TW  = 2 * W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en = 1'b0, cap_in = 1'b0, cap_ready = 1'b1;
  logic cap_valid, cap_overrun;
  logic [TW-1:0] cap_data, count;

  logic [TW-1:0] ref_cnt;
  logic [TW-1:0] exp_q[$];
  logic [15:0] lfsr = 16'hACE1;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cascade_timer_capture #(.CNT_W(W), .CARRY_DLY(D), .THRESH(THR)) u0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .cap_in(cap_in),
    .cap_ready(cap_ready), .cap_valid(cap_valid), .cap_data(cap_data),
    .cap_overrun(cap_overrun), .count(count)
  );

  // Reference time base
  always @(posedge clk) begin
    if (rst) ref_cnt <= '0;
    else if (cnt_en) ref_cnt <= ref_cnt + 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: live count (R2) and scoreboard pop (R4/R5)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(count == ref_cnt, "R2", count, ref_cnt);
      if (cap_valid && cap_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R7", cap_data, '0);
        else begin
          logic [TW-1:0] e;
          e = exp_q.pop_front();
          chk(cap_data == e, (e[W-1:0] < THR) ? "R4" : "R5", cap_data, e);
        end
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  // Driver: one-cycle strobe; replace drops the superseded expectation (R7)
  task automatic do_cap(input bit replace);
    if (replace && exp_q.size() > 0) void'(exp_q.pop_back());
    cap_in = 1'b1;
    exp_q.push_back(ref_cnt);
    tick(1);
    cap_in = 1'b0;
  endtask

  task automatic sweep(input int spacing, input int ncap, input bit rnd_en);
    for (int k = 0; k < ncap; k++) begin
      do_cap(0);
      for (int j = 1; j < spacing; j++) begin
        if (rnd_en) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          cnt_en = lfsr[0] | lfsr[1];
        end
        tick(1);
      end
    end
    cnt_en = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    @(negedge clk);
    // R1
    chk(count == '0, "R1", count, '0);
    chk(!cap_valid, "R1", TW'(cap_valid), '0);
    chk(!cap_overrun, "R1", TW'(cap_overrun), '0);
    @(posedge clk); #1;
    rst = 1'b0;
    cnt_en = 1'b1;
    tick(20);
    cnt_en = 1'b0;
    tick(5);
    cnt_en = 1'b1;

    // R3 latency
    do_cap(0);
    for (int k = 1; k <= D + 1; k++) begin
      @(negedge clk);
      chk(cap_valid == (k == D + 1), "R3", TW'(cap_valid), TW'(k == D + 1));
      @(posedge clk); #1;
    end
    tick(4);

    // R4/R5 across many wraps, all phases
    sweep(5, 300, 0);
    sweep(7, 200, 1);
    sweep(6, 150, 1);
    // R8: strobe on the handshake edge, spacing D+1
    sweep(D + 1, 300, 0);
    tick(D + 3);
    chk(!cap_overrun, "R8", TW'(cap_overrun), '0);
    chk(exp_q.size() == 0, "R8", TW'(exp_q.size()), '0);

    // R6 back-pressure
    cap_ready = 1'b0;
    do_cap(0);
    tick(D + 2);
    @(negedge clk);
    chk(cap_valid, "R6", TW'(cap_valid), 1);
    chk(cap_data == exp_q[0], "R6", cap_data, exp_q[0]);
    tick(4);
    @(negedge clk);
    chk(cap_valid && cap_data == exp_q[0], "R6", cap_data, exp_q[0]);
    @(posedge clk); #1;
    cap_ready = 1'b1;
    tick(3);
    chk(exp_q.size() == 0, "R6", TW'(exp_q.size()), '0);
    chk(!cap_overrun, "R8", TW'(cap_overrun), '0);

    // R7: strobe while pending
    do_cap(0);
    do_cap(1);
    @(negedge clk);
    chk(cap_overrun, "R7", TW'(cap_overrun), 1);
    tick(D + 3);
    chk(exp_q.size() == 0, "R7", TW'(exp_q.size()), '0);

    // R7: strobe while held unaccepted
    cap_ready = 1'b0;
    do_cap(0);
    tick(D + 2);
    do_cap(1);
    @(negedge clk);
    chk(!cap_valid, "R7", TW'(cap_valid), '0);
    @(posedge clk); #1;
    cap_ready = 1'b1;
    tick(D + 3);
    chk(exp_q.size() == 0, "R7", TW'(exp_q.size()), '0);

    // R9 sticky
    tick(50);
    @(negedge clk);
    chk(cap_overrun, "R9", TW'(cap_overrun), 1);
    @(posedge clk); #1;
    rst = 1'b1;
    tick(1);
    @(negedge clk);
    chk(!cap_overrun && count == '0, "R1", TW'(cap_overrun), '0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule